// File: doc/BRIEF.md
# CAN Receive Identifier Acceptance Filter

This block decides, frame by frame, whether a received CAN message is kept for the receive FIFO. It holds a bank of mask/identifier register pairs (four by default) and one enable register with one bit per pair. All of them are loaded through a plain write port. The frame decoder in front of it signals the start of each frame. At that moment the block takes a copy of the enable bits. Later the decoder presents the complete identifier word with a valid pulse. One clock after that pulse, the block issues either an accept pulse or a reject pulse. A hit vector comes out with the accept pulse and shows which filters matched.

A filter matches when the received word and the filter's identifier agree on every bit that the filter's mask sets. A frame is accepted when any enabled filter matches. When no filter was enabled at the start of the frame, every frame is accepted. A busy flag is high while a frame is being filtered. A filter's mask or identifier can be rewritten only while that filter is disabled and the block is not busy. Reset clears the enables and the controller, but it leaves the mask and identifier contents unchanged.

The controller has two states. `ST_IDLE` waits for a frame. `ST_ARMED` holds the enable copy and waits for the identifier. The transitions are:
- Start: `ST_IDLE` to `ST_ARMED` on `sof`.
- Restart: `ST_ARMED` to `ST_ARMED` on `sof` without `id_valid`, which takes a new enable copy.
- Decide: `ST_ARMED` to `ST_IDLE` on `id_valid`, which issues the decision.
- Hold: the state stays the same when neither input is present.

Top module: `can_accept_filter`

## Requirements
- R1: Filter k matches when `(mask_k & rx_id) == (mask_k & ident_k)`. With the decision pulse, `hit_vec[k]` is 1 exactly when filter k was enabled in the frame's enable copy and matches.
- R2: One clock after `id_valid` is sampled in `ST_ARMED`, exactly one of `accept` or `reject` pulses high for one cycle. `accept` is the OR of the hit bits. `hit_vec` is zero outside an accept pulse.
- R3: If all enable bits in the frame's copy are zero, the frame is accepted and `hit_vec` is zero.
- R4: The enable bits are copied at `sof`. Writes to the enable register after that do not change the decision for the frame. A `sof` that arrives while armed without `id_valid` takes a new copy.
- R5: The identifier word packs the fields as follows: bits 31:21 are the base identifier, bit 20 is SRR, bit 19 is IDE, bits 18:1 are the extended identifier and bit 0 is RTR. The mask and the identifier registers use the same packing. A standard-frame filter has its mask bits 18:0 at zero, so it ignores the extended and RTR bits but still compares SRR and IDE.
- R6: A write to filter k's mask or identifier is ignored when enable bit k is set or `busy` is high.
- R7: Reset clears the enable register, `busy` and the output pulses. The mask and identifier contents survive reset.
- R8: `busy` is high from the clock that samples `sof` until the decision clock. An `id_valid` that arrives in `ST_IDLE` produces no pulse.
- R9: The write address map is as follows: address 0 is the enable register, whose bits [NUM_FLT-1:0] are bit k for filter k; address 2k+1 is the mask of filter k; address 2k+2 is the identifier of filter k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears the enables and the controller |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | ID_W | Register write data |
| sof | input | 1 | Start-of-frame pulse |
| id_valid | input | 1 | Identifier word valid pulse |
| rx_id | input | ID_W | Received identifier word |
| busy | output | 1 | Filtering in progress |
| accept | output | 1 | Frame accepted pulse |
| reject | output | 1 | Frame rejected pulse |
| hit_vec | output | NUM_FLT | Per-filter match bits, valid with `accept` |

## Verification
The bench builds the block with its defaults: four filters over a 32-bit identifier word and a 4-bit address. This lets it load four filters of different kinds at the same time: a standard-frame filter, an exact extended filter, a filter on the extended field only, and a filter on the base identifier only. Frames are then chosen to light up different combinations of hit bits. With these values the bench can also change the enables in the middle of a frame, write to filters while they are in use, and check that a filter image set up before a reset still applies after it.

// File: rtl/caf_pkg.sv
package caf_pkg;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_ARMED = 1'b1
    } caf_state_e;

    function automatic logic masked_equal(input logic [31:0] msk,
                                          input logic [31:0] a,
                                          input logic [31:0] b);
        return (msk & a) == (msk & b);
    endfunction

endpackage

// File: rtl/caf_store.sv
module caf_store #(
    parameter int NUM_FLT = 4,
    parameter int ID_W    = 32,
    parameter int ADDR_W  = 4
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             busy,
    input  logic                             wr_en,
    input  logic [ADDR_W-1:0]                wr_addr,
    input  logic [ID_W-1:0]                  wr_data,
    output logic [NUM_FLT-1:0]               en_q,
    output logic [NUM_FLT-1:0][ID_W-1:0]     mask_q,
    output logic [NUM_FLT-1:0][ID_W-1:0]     ident_q
);

    localparam logic [ADDR_W-1:0] EN_ADDR = '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (wr_en && wr_addr == EN_ADDR) begin
            en_q <= wr_data[NUM_FLT-1:0];
        end
    end

    for (genvar k = 0; k < NUM_FLT; k++) begin : g_slot
        localparam logic [ADDR_W-1:0] MASK_ADDR  = ADDR_W'(2 * k + 1);
        localparam logic [ADDR_W-1:0] IDENT_ADDR = ADDR_W'(2 * k + 2);

        logic open_k;
        assign open_k = !en_q[k] && !busy;

        // Contents are deliberately not reset.
        always_ff @(posedge clk) begin
            if (wr_en && open_k && wr_addr == MASK_ADDR) begin
                mask_q[k] <= wr_data;
            end
            if (wr_en && open_k && wr_addr == IDENT_ADDR) begin
                ident_q[k] <= wr_data;
            end
        end

        assert_mask_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_addr == MASK_ADDR && (en_q[k] || busy)) |=> $stable(mask_q[k]));
        assert_ident_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_addr == IDENT_ADDR && (en_q[k] || busy)) |=> $stable(ident_q[k]));
    end

endmodule

// File: rtl/caf_compare.sv
module caf_compare #(
    parameter int NUM_FLT = 4,
    parameter int ID_W    = 32
) (
    input  logic [NUM_FLT-1:0]               en_snap,
    input  logic [NUM_FLT-1:0][ID_W-1:0]     mask_q,
    input  logic [NUM_FLT-1:0][ID_W-1:0]     ident_q,
    input  logic [ID_W-1:0]                  rx_id,
    output logic [NUM_FLT-1:0]               hit_raw
);
    import caf_pkg::*;

    for (genvar k = 0; k < NUM_FLT; k++) begin : g_cmp
        logic [31:0] m_w, a_w, b_w;
        assign m_w = 32'(mask_q[k]);
        assign a_w = 32'(rx_id);
        assign b_w = 32'(ident_q[k]);
        assign hit_raw[k] = en_snap[k] && masked_equal(m_w, a_w, b_w);
    end

endmodule

// File: rtl/caf_seq.sv
module caf_seq #(
    parameter int NUM_FLT = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sof,
    input  logic               id_valid,
    input  logic [NUM_FLT-1:0] en_live,
    input  logic [NUM_FLT-1:0] hit_raw,
    output logic [NUM_FLT-1:0] en_snap,
    output logic               busy,
    output logic               accept,
    output logic               reject,
    output logic [NUM_FLT-1:0] hit_vec
);
    import caf_pkg::*;

    caf_state_e state_q, state_d;
    logic       decide, take, pass;

    assign decide = (state_q == ST_ARMED) && id_valid;
    assign take   = sof && !decide;
    assign pass   = (en_snap == '0) || (|hit_raw);
    assign busy   = (state_q == ST_ARMED);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (sof)      state_d = ST_ARMED;  // start
            ST_ARMED: if (id_valid) state_d = ST_IDLE;   // decide; sof alone = restart
            default:                state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_snap <= '0;
            accept  <= 1'b0;
            reject  <= 1'b0;
            hit_vec <= '0;
        end else begin
            if (take) en_snap <= en_live;
            accept  <= decide && pass;
            reject  <= decide && !pass;
            hit_vec <= decide ? hit_raw : '0;
        end
    end

    assert_strobe_timing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept || reject) |-> ($past(id_valid) && $past(busy)));
    assert_strobe_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(accept && reject));
    assert_hits_need_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit_vec) |-> accept);
    assert_pass_all_R3: assert property (@(posedge clk) disable iff (!rst_n)
        reject |-> ($past(en_snap) != '0));
    assert_busy_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(sof));
    assert_snap_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$past(sof)) |-> $stable(en_snap));

endmodule

// File: rtl/can_accept_filter.sv
module can_accept_filter #(
    parameter int NUM_FLT = 4,
    parameter int ID_W    = 32,
    parameter int ADDR_W  = $clog2(2 * NUM_FLT + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [ID_W-1:0]    wr_data,
    input  logic               sof,
    input  logic               id_valid,
    input  logic [ID_W-1:0]    rx_id,
    output logic               busy,
    output logic               accept,
    output logic               reject,
    output logic [NUM_FLT-1:0] hit_vec
);

    logic [NUM_FLT-1:0]           en_q, en_snap, hit_raw;
    logic [NUM_FLT-1:0][ID_W-1:0] mask_q, ident_q;

    caf_store #(.NUM_FLT(NUM_FLT), .ID_W(ID_W), .ADDR_W(ADDR_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .busy    (busy),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .en_q    (en_q),
        .mask_q  (mask_q),
        .ident_q (ident_q)
    );

    caf_compare #(.NUM_FLT(NUM_FLT), .ID_W(ID_W)) u_compare (
        .en_snap (en_snap),
        .mask_q  (mask_q),
        .ident_q (ident_q),
        .rx_id   (rx_id),
        .hit_raw (hit_raw)
    );

    caf_seq #(.NUM_FLT(NUM_FLT)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .sof      (sof),
        .id_valid (id_valid),
        .en_live  (en_q),
        .hit_raw  (hit_raw),
        .en_snap  (en_snap),
        .busy     (busy),
        .accept   (accept),
        .reject   (reject),
        .hit_vec  (hit_vec)
    );

endmodule

// File: tb/test_can_accept_filter.sv
module test_can_accept_filter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        sof = 1'b0;
    logic        id_valid = 1'b0;
    logic [31:0] rx_id = '0;
    logic        busy, accept, reject;
    logic [3:0]  hit_vec;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    can_accept_filter i_can_accept_filter (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .sof(sof), .id_valid(id_valid), .rx_id(rx_id),
        .busy(busy), .accept(accept), .reject(reject), .hit_vec(hit_vec)
    );

    function automatic logic [31:0] pack(input logic [10:0] base, input logic srr,
                                         input logic ide, input logic [17:0] ext,
                                         input logic rtr);
        return {base, srr, ide, ext, rtr};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic start_frame();
        @(negedge clk);
        sof = 1'b1;
        @(negedge clk);
        sof = 1'b0;
        chk("R8 busy after sof", 32'(busy), 32'd1);
    endtask

    // R2: decision one clock after id_valid, gone the clock after
    task automatic finish_frame(input string req, input logic [31:0] id,
                                input logic exp_acc, input logic [3:0] exp_hit);
        rx_id = id; id_valid = 1'b1;
        @(negedge clk);
        id_valid = 1'b0;
        chk({req, " accept"}, 32'(accept), 32'(exp_acc));
        chk({req, " reject"}, 32'(reject), 32'(!exp_acc));
        chk({req, " hit_vec"}, 32'(hit_vec), 32'(exp_hit));
        chk("R8 busy clear at decision", 32'(busy), 32'd0);
        @(negedge clk);
        chk("R2 single-cycle strobe", 32'({accept, reject, hit_vec}), 32'd0);
    endtask

    task automatic frame(input string req, input logic [31:0] id,
                         input logic exp_acc, input logic [3:0] exp_hit);
        start_frame();
        finish_frame(req, id, exp_acc, exp_hit);
    endtask

    localparam logic [31:0] F0M = 32'hFFF8_0000;  // base+SRR+IDE (standard)
    localparam logic [31:0] F2M = 32'h0007_FFFE;  // extended field only
    localparam logic [31:0] F3M = 32'hFFE0_0000;  // base only

    task automatic t_reset();
        @(negedge clk);
        chk("R7 busy at reset", 32'(busy), 32'd0);
        chk("R7 strobes at reset", 32'({accept, reject, hit_vec}), 32'd0);
        frame("R3 pass-all after reset", pack(11'h5A5, 0, 1, 18'h3, 1), 1'b1, 4'b0000);
    endtask

    task automatic t_program();
        reg_write(4'd1, F0M);
        reg_write(4'd2, pack(11'h123, 0, 0, 0, 0));
        reg_write(4'd3, 32'hFFFF_FFFF);
        reg_write(4'd4, pack(11'h123, 1, 1, 18'h15555, 0));
        reg_write(4'd5, F2M);
        reg_write(4'd6, pack(11'h000, 0, 0, 18'h15555, 0));
        reg_write(4'd7, F3M);
        reg_write(4'd8, pack(11'h7FF, 0, 0, 0, 0));
    endtask

    task automatic t_standard();
        reg_write(4'd0, 32'h1);  // R9 enable register
        frame("R5 std ignores ext/rtr", pack(11'h123, 0, 0, 18'h2AAAA, 1), 1'b1, 4'b0001);
        frame("R1 base mismatch", pack(11'h124, 0, 0, 0, 0), 1'b0, 4'b0000);
        frame("R5 IDE compared", pack(11'h123, 0, 1, 0, 0), 1'b0, 4'b0000);
    endtask

    task automatic t_multi();
        reg_write(4'd0, 32'hF);
        frame("R1 hits 1,2", pack(11'h123, 1, 1, 18'h15555, 0), 1'b1, 4'b0110);
        frame("R1 hit 3", pack(11'h7FF, 0, 0, 0, 0), 1'b1, 4'b1000);
        frame("R1 hits 0,2", pack(11'h123, 0, 0, 18'h15555, 0), 1'b1, 4'b0101);
        frame("R2 none match", pack(11'h001, 0, 0, 0, 0), 1'b0, 4'b0000);
        reg_write(4'd0, 32'h4);
        frame("R1 subset enable", pack(11'h123, 1, 1, 18'h15555, 0), 1'b1, 4'b0100);
    endtask

    task automatic t_freeze();
        reg_write(4'd0, 32'h1);
        start_frame();
        reg_write(4'd0, 32'h0);
        finish_frame("R4 old enables kept", pack(11'h001, 0, 0, 0, 0), 1'b0, 4'b0000);
        reg_write(4'd0, 32'h1);
        start_frame();
        reg_write(4'd0, 32'h0);
        start_frame();  // restart takes a new copy
        finish_frame("R4 restart resamples", pack(11'h001, 0, 0, 0, 0), 1'b1, 4'b0000);
        start_frame();
        reg_write(4'd0, 32'h1);
        finish_frame("R4 late enable ignored", pack(11'h001, 0, 0, 0, 0), 1'b1, 4'b0000);
    endtask

    task automatic t_gating();
        // enable bit 0 is set from the previous task
        reg_write(4'd1, 32'h0);
        frame("R6 write refused while enabled", pack(11'h001, 0, 0, 0, 0), 1'b0, 4'b0000);
        reg_write(4'd0, 32'h0);
        start_frame();
        reg_write(4'd1, 32'h0);
        finish_frame("R6 busy frame", pack(11'h001, 0, 0, 0, 0), 1'b1, 4'b0000);
        reg_write(4'd0, 32'h1);
        frame("R6 write refused while busy", pack(11'h001, 0, 0, 0, 0), 1'b0, 4'b0000);
        reg_write(4'd0, 32'h0);
        reg_write(4'd2, pack(11'h001, 0, 0, 0, 0));
        reg_write(4'd0, 32'h1);
        frame("R6 open write taken", pack(11'h001, 0, 0, 0, 0), 1'b1, 4'b0001);
        reg_write(4'd0, 32'h0);
        reg_write(4'd2, pack(11'h123, 0, 0, 0, 0));
    endtask

    task automatic t_idle_valid();
        @(negedge clk);
        rx_id = 32'h0; id_valid = 1'b1;
        @(negedge clk);
        id_valid = 1'b0;
        chk("R8 idle id_valid no strobe", 32'({accept, reject}), 32'd0);
        chk("R8 idle id_valid no busy", 32'(busy), 32'd0);
    endtask

    task automatic t_reset_keep();
        reg_write(4'd0, 32'h1);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        frame("R7 enables cleared", pack(11'h001, 0, 0, 0, 0), 1'b1, 4'b0000);
        reg_write(4'd0, 32'h1);
        frame("R7 filter kept match", pack(11'h123, 0, 0, 18'h1, 0), 1'b1, 4'b0001);
        frame("R7 filter kept miss", pack(11'h124, 0, 0, 0, 0), 1'b0, 4'b0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_program();
        t_standard();
        t_multi();
        t_freeze();
        t_gating();
        t_idle_valid();
        t_reset_keep();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule